// File: doc/BRIEF.md
# Envelope Signature Counter with Acceptance Window

This block turns the one-bit output of a first-order sigma-delta modulator into a single signed test signature, then judges it. The modulator samples the detected envelope of a device's response to a two-tone stimulus. Integration runs over a whole number of evaluation periods, so the count covers exactly M times N samples. Here N is the integer number of samples per evaluation period, which is twice the beat period, and M is the number of periods to integrate.

A run starts with a one-cycle start pulse. The block then adds one for each high bit and subtracts one for each low bit. When the last sample is in, it compares the total with a programmable signed window and raises done together with exactly one of pass or fail. A larger M lowers the relative error of the signature but makes the test longer. A typical setting is N = 96 with M of 2, 5 or 10.

Top module: `envsig_judge`

## Requirements
- R1: A start pulse sampled at a clock edge clears the signature to zero and clears done, pass and fail at that edge. It also captures osrN and periodsM for the run.
- R2: At each of the osrN·periodsM clock edges after the start edge, the signature changes by +1 if bitIn is 1 and by −1 if bitIn is 0.
- R3: The signature is two's complement, OSR_W+PER_W+1 bits wide. It holds ±osrN·periodsM without overflow for osrN up to 2^OSR_W−1 and periodsM up to 2^PER_W−1 (255 and 15 by default).
- R4: done rises at the clock edge after the last sample edge. After that, done, pass, fail and signature hold steady until the next start or reset, whatever bitIn does.
- R5: pass is 1 with done when winLow ≤ signature ≤ winHigh. The comparison is signed and both limits are inclusive.
- R6: fail is 1 with done when the signature lies outside the window. pass and fail are never both 1, and neither is 1 while done is 0.
- R7: When winLow > winHigh (signed), the verdict is fail.
- R8: A start during a run restarts it and drops the partial count. A start in the cycle where the verdict would be taken also drops that verdict: done stays 0 and the new run proceeds.
- R9: After reset, signature is 0 and done, pass and fail are 0.
- R10: Changes to osrN and periodsM after the start edge do not affect the length of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins (or restarts) a run |
| osrN | input | OSR_W | Samples per evaluation period, at least 1 |
| periodsM | input | PER_W | Evaluation periods per run, at least 1 |
| winLow | input | OSR_W+PER_W+1 | Signed lower window limit |
| winHigh | input | OSR_W+PER_W+1 | Signed upper window limit |
| bitIn | input | 1 | Modulator bitstream |
| signature | output | OSR_W+PER_W+1 | Signed running or final count |
| pass | output | 1 | Signature inside window |
| fail | output | 1 | Signature outside window or window inverted |
| done | output | 1 | Verdict valid |

## Verification
A new start can arrive in the same cycle that the verdict is taken. The restart must win: the verdict is discarded and the accumulator is cleared rather than judged. The bench provokes this by raising start right after the last sample bit. It then expects done low with a zero signature one cycle later, followed by a correct verdict for the new run. A start in the middle of a run is judged the same way, against the count of the second run alone.

// File: rtl/envsig_pkg.sv
package envsig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_JUDGE = 2'd2
  } runState_t;

  typedef struct packed {
    logic clearAcc;
    logic accumulate;
    logic judge;
  } envStrobe_t;

endpackage

// File: rtl/envsig_ctrl.sv
module envsig_ctrl
  import envsig_pkg::*;
#(
  parameter int OSR_W = 8,
  parameter int PER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OSR_W-1:0] osrN,
  input  logic [PER_W-1:0] periodsM,
  output envStrobe_t       strobe
);

  runState_t        state;
  logic [OSR_W-1:0] capN;
  logic [PER_W-1:0] capM;
  logic [OSR_W-1:0] sampleCnt;
  logic [PER_W-1:0] periodCnt;
  logic             lastInPeriod;
  logic             lastPeriod;

  assign lastInPeriod = (sampleCnt == capN - 1'b1);
  assign lastPeriod   = (periodCnt == capM - 1'b1);

  // Start overrides everything, including a pending verdict.
  always_comb begin
    strobe = '0;
    if (start) begin
      strobe.clearAcc = 1'b1;
    end else begin
      strobe.accumulate = (state == ST_RUN);
      strobe.judge      = (state == ST_JUDGE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      capN      <= '0;
      capM      <= '0;
      sampleCnt <= '0;
      periodCnt <= '0;
    end else if (start) begin
      state     <= ST_RUN;
      capN      <= osrN;
      capM      <= periodsM;
      sampleCnt <= '0;
      periodCnt <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (lastInPeriod) begin
            sampleCnt <= '0;
            if (lastPeriod) begin
              state <= ST_JUDGE;
            end else begin
              periodCnt <= periodCnt + 1'b1;
            end
          end else begin
            sampleCnt <= sampleCnt + 1'b1;
          end
        end
        ST_JUDGE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/envsig_datapath.sv
module envsig_datapath
  import envsig_pkg::*;
#(
  parameter int SIG_W = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  envStrobe_t              strobe,
  input  logic                    bitIn,
  input  logic signed [SIG_W-1:0] winLow,
  input  logic signed [SIG_W-1:0] winHigh,
  output logic signed [SIG_W-1:0] signature,
  output logic                    pass,
  output logic                    fail,
  output logic                    done
);

  localparam logic signed [SIG_W-1:0] STEP_UP   = SIG_W'(1);
  localparam logic signed [SIG_W-1:0] STEP_DOWN = {SIG_W{1'b1}};

  logic signed [SIG_W-1:0] acc;
  logic                    windowOk;
  logic                    inWindow;

  assign windowOk  = (winLow <= winHigh);
  assign inWindow  = windowOk && (acc >= winLow) && (acc <= winHigh);
  assign signature = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      pass <= 1'b0;
      fail <= 1'b0;
      done <= 1'b0;
    end else if (strobe.clearAcc) begin
      acc  <= '0;
      pass <= 1'b0;
      fail <= 1'b0;
      done <= 1'b0;
    end else begin
      if (strobe.accumulate) begin
        acc <= acc + (bitIn ? STEP_UP : STEP_DOWN);
      end
      if (strobe.judge) begin
        done <= 1'b1;
        pass <= inWindow;
        fail <= !inWindow;
      end
    end
  end

endmodule

// File: rtl/envsig_judge.sv
module envsig_judge
  import envsig_pkg::*;
#(
  parameter int OSR_W = 8,
  parameter int PER_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [OSR_W-1:0]           osrN,
  input  logic [PER_W-1:0]           periodsM,
  input  logic signed [OSR_W+PER_W:0] winLow,
  input  logic signed [OSR_W+PER_W:0] winHigh,
  input  logic                       bitIn,
  output logic signed [OSR_W+PER_W:0] signature,
  output logic                       pass,
  output logic                       fail,
  output logic                       done
);

  localparam int SIG_W = OSR_W + PER_W + 1;

  envStrobe_t strobe;

  envsig_ctrl #(.OSR_W(OSR_W), .PER_W(PER_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .osrN     (osrN),
    .periodsM (periodsM),
    .strobe   (strobe)
  );

  envsig_datapath #(.SIG_W(SIG_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .bitIn     (bitIn),
    .winLow    (winLow),
    .winHigh   (winHigh),
    .signature (signature),
    .pass      (pass),
    .fail      (fail),
    .done      (done)
  );

endmodule

// File: rtl/envsig_judge_checker.sv
module envsig_judge_checker #(
  parameter int OSR_W = 8,
  parameter int PER_W = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start,
  input logic [OSR_W-1:0]            osrN,
  input logic [PER_W-1:0]            periodsM,
  input logic signed [OSR_W+PER_W:0] winLow,
  input logic signed [OSR_W+PER_W:0] winHigh,
  input logic signed [OSR_W+PER_W:0] signature,
  input logic                        pass,
  input logic                        fail,
  input logic                        done
);

  logic [OSR_W-1:0] chkN;
  logic [PER_W-1:0] chkM;
  int               bound;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chkN <= '0;
      chkM <= '0;
    end else if (start) begin
      chkN <= osrN;
      chkM <= periodsM;
    end
  end

  assign bound = int'(chkN) * int'(chkM);

  // R1: start clears count and verdict
  p_clear_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (signature == 0 && !done && !pass && !fail));

  // R3: count never exceeds the run length in magnitude
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(signature) <= bound) && (int'(signature) >= -bound));

  // R4: verdict and signature hold once done
  p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(signature) && $stable(pass) && $stable(fail)));

  // R5: a pass verdict lies inside the window that was sampled
  p_pass_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> (signature >= $past(winLow) && signature <= $past(winHigh)));

  // R6: exactly one verdict with done, none without
  p_verdict_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail));
  p_no_verdict_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!pass && !fail));

  // R7: an inverted window always fails
  p_inverted_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && $past(winLow > winHigh)) |-> fail);

endmodule

bind envsig_judge envsig_judge_checker #(.OSR_W(OSR_W), .PER_W(PER_W)) u_chk (.*);

// File: tb/envsig_judge_test.sv
module envsig_judge_test;

  localparam int OSR_W = 8;
  localparam int PER_W = 4;
  localparam int SW    = OSR_W + PER_W + 1;
  localparam int NV    = 9;

  // columns: N, M, hiPer, hiCnt, low, high
  localparam int VEC [NV][6] = '{
    '{ 96,  2, 4, 3,    90,   100},
    '{ 96,  5, 2, 1,    -5,     5},
    '{ 96, 10, 1, 1,     0,   959},
    '{  8,  3, 3, 0,   -24,   -24},
    '{ 10,  2, 5, 2,    -3,    10},
    '{ 10,  2, 5, 2,   -10,    -4},
    '{ 12,  1, 1, 1,    20,     5},
    '{255, 15, 1, 1,  3825,  3825},
    '{255, 15, 1, 0, -3825, -3825}
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start = 1'b0;
  logic [OSR_W-1:0]     osrN = '0;
  logic [PER_W-1:0]     periodsM = '0;
  logic signed [SW-1:0] winLow = '0;
  logic signed [SW-1:0] winHigh = '0;
  logic                 bitIn = 1'b0;
  logic signed [SW-1:0] signature;
  logic                 pass, fail, done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  envsig_judge #(.OSR_W(OSR_W), .PER_W(PER_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .osrN(osrN), .periodsM(periodsM),
    .winLow(winLow), .winHigh(winHigh), .bitIn(bitIn),
    .signature(signature), .pass(pass), .fail(fail), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseStart(input int n, input int m);
    start = 1'b1; osrN = OSR_W'(n); periodsM = PER_W'(m);
    @(posedge clk); @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(input int cnt, input int hiPer, input int hiCnt);
    for (int k = 0; k < cnt; k++) begin
      bitIn = ((k % hiPer) < hiCnt);
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic judgeCheck(input int expSig, input int lo, input int hi, input string req);
    bit expPass;
    expPass = (lo <= hi) && (expSig >= lo) && (expSig <= hi);
    check(done == 1'b0, {req, " done not early (R4)"}, int'(done), 0);
    @(posedge clk); @(negedge clk);
    check(done == 1'b1, {req, " done (R4)"}, int'(done), 1);
    check(int'(signature) == expSig, {req, " signature (R2)"}, int'(signature), expSig);
    check(pass == expPass && fail == !expPass, {req, " verdict (R5/R6)"},
          int'({pass, fail}), int'({expPass, !expPass}));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(signature == 0 && !done && !pass && !fail, "R9 reset state",
          int'({done, pass, fail}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table-driven runs
    for (int v = 0; v < NV; v++) begin
      int n, m, hp, hc, lo, hi, ones, expSig;
      n = VEC[v][0]; m = VEC[v][1]; hp = VEC[v][2]; hc = VEC[v][3];
      lo = VEC[v][4]; hi = VEC[v][5];
      ones = 0;
      for (int k = 0; k < n * m; k++) if ((k % hp) < hc) ones++;
      expSig = 2 * ones - n * m;
      winLow = SW'(lo); winHigh = SW'(hi);
      pulseStart(n, m);
      check(signature == 0 && !done, "R1 cleared at start", int'(signature), 0);
      feed(n * m, hp, hc);
      if (lo > hi) check(1'b1, "R7 inverted window case", 0, 0);
      judgeCheck(expSig, lo, hi, (v >= 7) ? "R3 full scale" : "R2 table");
    end

    // R4: hold after done while bitIn toggles
    begin
      int held;
      held = int'(signature);
      for (int k = 0; k < 6; k++) begin
        bitIn = k[0];
        @(posedge clk); @(negedge clk);
      end
      check(int'(signature) == held && done && pass, "R4 hold after done",
            int'(signature), held);
    end

    // R10: parameter change mid-run ignored
    winLow = SW'(20); winHigh = SW'(20);
    pulseStart(10, 2);
    feed(3, 1, 1);
    osrN = OSR_W'(3); periodsM = PER_W'(1);
    feed(17, 1, 1);
    judgeCheck(20, 20, 20, "R10 captured N and M");

    // R8: restart in mid-run
    winLow = SW'(-4); winHigh = SW'(-4);
    pulseStart(10, 2);
    feed(7, 1, 1);
    pulseStart(4, 1);
    check(signature == 0 && !done, "R8 mid-run restart clears", int'(signature), 0);
    feed(4, 1, 0);
    judgeCheck(-4, -4, -4, "R8 mid-run restart");

    // R8: restart in the verdict cycle
    winLow = SW'(-10); winHigh = SW'(10);
    pulseStart(4, 1);
    feed(4, 1, 1);
    pulseStart(4, 1);
    check(!done && signature == 0, "R8 verdict dropped on restart",
          int'({done, signature != 0}), 0);
    feed(4, 2, 1);
    judgeCheck(0, -10, 10, "R8 run after dropped verdict");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule